// File: doc/BRIEF.md
# Register Range Access Guard

This block watches register accesses on a request interface and flags the ones that land inside a protected range. It holds a small bank of protection entries. Software loads each entry by index through a configuration write port. Each entry describes one range with three parts: a base register index, a length given as a power of two, and two independent blocking enables, one for reads and one for writes. A range can therefore forbid all access, or forbid only writes while still allowing reads.

Every request is checked against all entries in the same cycle. A blocked request raises a violation flag for as long as the request is presented. The address and direction of the first violation are kept in a sticky status record until software clears it. The access itself is not carried out or stopped here. A downstream consumer acts on the flag.

Top module: `rgn_guard`

## Requirements
- R1: After reset every entry holds zero, the status record is empty (`stat_valid_o` low), and no request raises `viol_o`.
- R2: When `cfg_we_i` is high at a clock edge, entry `cfg_idx_i` takes the value of `cfg_data_i` from the next cycle on. A request in the same cycle as the write is still judged against the old entry contents.
- R3: Entry word layout: bit 30 blocks reads, bit 29 blocks writes, bits 28:24 hold log2 of the range length, and bits 19:2 hold the base register index.
- R4: An entry covers every register from its aligned base up to the aligned base plus length minus one. The aligned base is the base with its low log2(length) bits cleared, so base 0x007 with length 4 covers 0x004 to 0x007. A log2 length of 18 or more covers the whole 18-bit register space.
- R5: Read blocking and write blocking act independently. An entry with both blocking bits clear never matches.
- R6: `viol_o` is high in the same cycle as a valid request exactly when at least one entry covers `req_addr_i` and blocks the direction given by `req_write_i`. Entries combine by OR, with no priority. A request with `req_valid_i` low never violates.
- R7: On the first violation while the status record is empty, the next cycle shows `stat_valid_o` high with the violating address and direction (`stat_write_o` is 1 for a write). Later violations leave the record unchanged.
- R8: `stat_clr_i` empties the record from the next cycle. If a violation arrives in the same cycle as the clear, that violation is captured instead.
- R9: Entry word bits 31, 23:20 and 1:0 have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Entry index to write |
| cfg_data_i | input | 32 | Entry word to write |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 18 | Register index of the request |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| viol_o | output | 1 | Request is blocked (same cycle) |
| stat_clr_i | input | 1 | Clear the sticky status record |
| stat_valid_o | output | 1 | Status record holds a violation |
| stat_addr_o | output | 18 | Address of the captured violation |
| stat_write_o | output | 1 | Direction of the captured violation |

## Verification
Two pairs of events can fall in the same cycle. The first is a status clear together with a new violation: the bench raises `stat_clr_i` in the same cycle as a blocked write, then checks that the record is full again with that write's address and direction rather than empty. The second is an entry rewrite together with a request that the new entry would block: the bench checks that `viol_o` stays low in the write cycle and goes high one cycle later while the same request is still held.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;
    localparam int ADDR_W   = 18;
    localparam int LG_W     = 5;
    localparam int CFG_W    = 32;
    localparam int RD_BIT   = 30;
    localparam int WR_BIT   = 29;
    localparam int LG_LSB   = 24;
    localparam int BASE_LSB = 2;

    typedef struct packed {
        logic              rd_blk;
        logic              wr_blk;
        logic [LG_W-1:0]   lg;
        logic [ADDR_W-1:0] base;
    } prot_ent_t;

    // bits at positions below lg are don't-care in the range compare
    function automatic logic [ADDR_W-1:0] keep_mask(input logic [LG_W-1:0] lg);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i >= int'(lg));
        end
        return m;
    endfunction
endpackage

// File: rtl/rgn_entry_bank.sv
module rgn_entry_bank
    import rgn_guard_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we_i,
    input  logic [IDX_W-1:0]        cfg_idx_i,
    input  logic [CFG_W-1:0]        cfg_data_i,
    output prot_ent_t [N_ENT-1:0]   ents_o
);
    typedef struct packed {
        prot_ent_t [N_ENT-1:0] ent;
    } bank_st_t;

    bank_st_t st_d, st_q;
    prot_ent_t new_ent;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_data_i[31], cfg_data_i[23:20], cfg_data_i[1:0]};

    always_comb begin
        new_ent.rd_blk = cfg_data_i[RD_BIT];
        new_ent.wr_blk = cfg_data_i[WR_BIT];
        new_ent.lg     = cfg_data_i[LG_LSB +: LG_W];
        new_ent.base   = cfg_data_i[BASE_LSB +: ADDR_W];
        st_d = st_q;
        if (cfg_we_i && (int'(cfg_idx_i) < N_ENT)) begin
            st_d.ent[cfg_idx_i] = new_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ents_o = st_q.ent;

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && int'(cfg_idx_i) < N_ENT) |=>
            (ents_o[$past(cfg_idx_i)].base == $past(cfg_data_i[BASE_LSB +: ADDR_W]))
         && (ents_o[$past(cfg_idx_i)].lg == $past(cfg_data_i[LG_LSB +: LG_W]))
         && (ents_o[$past(cfg_idx_i)].rd_blk == $past(cfg_data_i[RD_BIT]))
         && (ents_o[$past(cfg_idx_i)].wr_blk == $past(cfg_data_i[WR_BIT])));

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(ents_o));
endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_guard_pkg::*;
(
    input  prot_ent_t          ent_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               write_i,
    output logic               hit_o
);
    logic [ADDR_W-1:0] mask;
    logic              in_rng;
    logic              blocks;

    always_comb begin
        mask   = keep_mask(ent_i.lg);
        in_rng = ((addr_i ^ ent_i.base) & mask) == '0;
        blocks = write_i ? ent_i.wr_blk : ent_i.rd_blk;
        hit_o  = in_rng && blocks;
    end

    always_comb begin
        if (hit_o) begin
            p_disabled_silent_r5: assert (ent_i.rd_blk || ent_i.wr_blk);
        end
    end
endmodule

// File: rtl/rgn_status.sv
module rgn_status
    import rgn_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               viol_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               write_i,
    input  logic               clr_i,
    output logic               vld_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               write_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.vld = 1'b0;
        if (viol_i && (!st_q.vld || clr_i)) begin
            st_d.vld  = 1'b1;
            st_d.addr = addr_i;
            st_d.wr   = write_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o   = st_q.vld;
    assign addr_o  = st_q.addr;
    assign write_o = st_q.wr;

    p_capture_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_i && !vld_o) |=> (vld_o && addr_o == $past(addr_i) && write_o == $past(write_i)));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !clr_i) |=> (vld_o && $stable(addr_o) && $stable(write_o)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !viol_i) |=> !vld_o);

    p_clear_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && viol_i) |=> (vld_o && addr_o == $past(addr_i)));
endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
    import rgn_guard_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [CFG_W-1:0]   cfg_data_i,
    input  logic               req_valid_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic               req_write_i,
    output logic               viol_o,
    input  logic               stat_clr_i,
    output logic               stat_valid_o,
    output logic [ADDR_W-1:0]  stat_addr_o,
    output logic               stat_write_o
);
    prot_ent_t [N_ENT-1:0] ents;
    logic      [N_ENT-1:0] hits;

    rgn_entry_bank #(.N_ENT(N_ENT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_idx_i  (cfg_idx_i),
        .cfg_data_i (cfg_data_i),
        .ents_o     (ents)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_match
        rgn_match u_match (
            .ent_i   (ents[g]),
            .addr_i  (req_addr_i),
            .write_i (req_write_i),
            .hit_o   (hits[g])
        );
    end

    assign viol_o = req_valid_i && (|hits);

    rgn_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .viol_i  (viol_o),
        .addr_i  (req_addr_i),
        .write_i (req_write_i),
        .clr_i   (stat_clr_i),
        .vld_o   (stat_valid_o),
        .addr_o  (stat_addr_o),
        .write_o (stat_write_o)
    );

    p_status_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_valid_o) |-> $past(viol_o));
endmodule

// File: tb/tb_rgn_guard.sv
module tb_rgn_guard;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT = 8;
    localparam int IDX_W = $clog2(N_ENT);
    localparam int NV = 20;

    // {valid, write, addr[17:0], expected viol}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 18'h00003, 1'b0},
        {1'b0, 1'b0, 18'h00005, 1'b0},
        {1'b1, 1'b0, 18'h00004, 1'b1},
        {1'b1, 1'b1, 18'h00007, 1'b1},
        {1'b1, 1'b1, 18'h00008, 1'b0},
        {1'b1, 1'b1, 18'h000FF, 1'b0},
        {1'b1, 1'b1, 18'h00100, 1'b1},
        {1'b1, 1'b1, 18'h0010F, 1'b1},
        {1'b1, 1'b0, 18'h0010F, 1'b0},
        {1'b1, 1'b1, 18'h00110, 1'b0},
        {1'b1, 1'b0, 18'h00200, 1'b1},
        {1'b1, 1'b1, 18'h00200, 1'b0},
        {1'b1, 1'b0, 18'h00201, 1'b0},
        {1'b1, 1'b0, 18'h00300, 1'b0},
        {1'b1, 1'b1, 18'h00304, 1'b0},
        {1'b1, 1'b0, 18'h00400, 1'b1},
        {1'b1, 1'b0, 18'h00401, 1'b1},
        {1'b1, 1'b0, 18'h00402, 1'b0},
        {1'b1, 1'b1, 18'h00400, 1'b0},
        {1'b1, 1'b0, 18'h00006, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [IDX_W-1:0]  cfg_idx_i = '0;
    logic [31:0]       cfg_data_i = '0;
    logic              req_valid_i = 1'b0;
    logic [17:0]       req_addr_i = '0;
    logic              req_write_i = 1'b0;
    logic              viol_o;
    logic              stat_clr_i = 1'b0;
    logic              stat_valid_o;
    logic [17:0]       stat_addr_o;
    logic              stat_write_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    rgn_guard #(.N_ENT(N_ENT)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_data_i(cfg_data_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_write_i(req_write_i),
        .viol_o(viol_o), .stat_clr_i(stat_clr_i),
        .stat_valid_o(stat_valid_o), .stat_addr_o(stat_addr_o), .stat_write_o(stat_write_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx); cfg_data_i = data;
        req_valid_i = 1'b0;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic apply(input logic v, input logic w, input logic [17:0] a,
                         input logic exp, input string tag);
        @(negedge clk);
        req_valid_i = v; req_write_i = w; req_addr_i = a;
        #1 check(tag, 32'(viol_o), 32'(exp));
    endtask

    task automatic idle_stat(input logic ev, input logic [17:0] ea,
                             input logic ew, input string tag);
        @(negedge clk);
        req_valid_i = 1'b0; stat_clr_i = 1'b0;
        #1;
        check({tag, " valid"}, 32'(stat_valid_o), 32'(ev));
        if (ev) begin
            check({tag, " addr"}, 32'(stat_addr_o), 32'(ea));
            check({tag, " dir"}, 32'(stat_write_o), 32'(ew));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1 check("R1 status empty", 32'(stat_valid_o), 0);
        apply(1'b1, 1'b0, 18'h00000, 1'b0, "R1 zero entries read");
        apply(1'b1, 1'b1, 18'h00000, 1'b0, "R1 zero entries write");

        // R3/R4/R5/R9: entry setup
        cfg(0, 32'h6200_001C); // both, len 4, base 0x007 -> 0x004..0x007
        cfg(1, 32'h2400_0400); // write only, len 16 at 0x100
        cfg(2, 32'h4000_0800); // read only, single reg 0x200
        cfg(3, 32'h0300_0C00); // disabled, len 8 at 0x300
        cfg(4, 32'hC1F0_1007); // read, len 2, base 0x401, junk bits set (R9)

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][20], VEC[i][19], VEC[i][18:1], VEC[i][0], "R3/R4/R5/R6/R9 vector");
        end

        // R7: first violation 0x004 read kept, later ones ignored
        idle_stat(1'b1, 18'h00004, 1'b0, "R7 first kept");

        // R8: clear
        @(negedge clk) stat_clr_i = 1'b1;
        idle_stat(1'b0, 18'h0, 1'b0, "R8 cleared");

        // R8: clear and violation in the same cycle
        @(negedge clk);
        stat_clr_i = 1'b1; req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 18'h00100;
        #1 check("R8 race viol", 32'(viol_o), 1);
        idle_stat(1'b1, 18'h00100, 1'b1, "R8 race captured");

        // R7: no overwrite by a later violation
        apply(1'b1, 1'b0, 18'h00005, 1'b1, "R7 second viol");
        idle_stat(1'b1, 18'h00100, 1'b1, "R7 no overwrite");

        // R4: length 2^18 covers everything, writes only (R5)
        cfg(7, 32'h3200_0000);
        apply(1'b1, 1'b1, 18'h3FFFF, 1'b1, "R4 full space write");
        apply(1'b1, 1'b0, 18'h3FFFF, 1'b0, "R5 full space read");
        cfg(7, 32'h0000_0000);
        apply(1'b1, 1'b1, 18'h3FFFF, 1'b0, "R2 entry rewritten to zero");

        // R2: config write and request in the same cycle
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = 3'd3; cfg_data_i = 32'h6300_0C00;
        req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 18'h00300;
        #1 check("R2 old entry used", 32'(viol_o), 0);
        @(negedge clk);
        cfg_we_i = 1'b0;
        #1 check("R2 new entry active", 32'(viol_o), 1);
        @(negedge clk) req_valid_i = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule